// File: doc/BRIEF.md
# Banked Dual-Access Instruction SRAM

This block is a 16 KB on-chip instruction store made of four single-ported sub-banks. Two requesters share it. One is a read-only 64-bit core instruction fetch port. The other is a 64-bit system DMA port that can read, and is the only way to write. Address bits [13:12] pick a sub-bank, so each sub-bank holds one contiguous 4 KB region. Bits [11:3] pick the 64-bit word inside that sub-bank. Bits [2:0] are ignored, because every access is a whole aligned 64-bit word.

When the two ports address different sub-banks in the same cycle, both are served. When they address the same sub-bank, the DMA port wins and the fetch is held off. The fetch keeps its request and address asserted until it is granted. A request is accepted in the cycle its ready is high, and its response (valid, error and data) appears on the next cycle.

A separate strobe marks an access from the core data-address path into this memory's address space. Such an access is refused and produces an exception pulse. A two-bit control register holds an enable bit and a cache-mode bit, and it accepts writes only in supervisor or emulation mode. The memory is serviced only when the enable bit is 1 and the cache-mode bit is 0. Otherwise every accepted request completes with an error and the stored contents are left unchanged.

Top module: `imem_dual_sram`

## Requirements
- R1: After reset, fetch_valid, dma_valid and dp_exc are 0. cfg_q is 2'b01: bit 0 is the enable bit, set, and bit 1 is the cache-mode bit, clear.
- R2: A DMA write (dma_we=1) updates only the bytes whose dma_be bit is 1. Bit i covers data bits [8i+7:8i]. Bytes whose enable bit is 0 keep their previous value.
- R3: A fetch is accepted in a cycle where fetch_ready=1. On the next cycle fetch_valid=1 and fetch_data is the word at sub-bank addr[13:12], index addr[11:3]. Bits [2:0] have no effect.
- R4: When fetch_req and dma_req are both high and addr[13:12] differ, fetch_ready=1 and both requests are serviced in that cycle.
- R5: When both requests are high and addr[13:12] match, fetch_ready=0 and the DMA access proceeds. No fetch response follows. A held fetch is served once the collision clears.
- R6: dp_req=1 causes dp_exc=1 on the next cycle, and dp_exc is 0 otherwise.
- R7: cfg_we loads cfg_wdata into cfg_q only when priv_mode is 1 (supervisor) or 2 (emulation). For priv_mode 0 (user) or 3 the write is ignored.
- R8: While cfg_q is not 2'b01, every accepted fetch or DMA request returns valid with err=1 and data 0. A DMA write made in this state leaves memory unchanged.
- R9: dma_ready equals dma_req. On the cycle after an accepted DMA request, dma_valid=1. dma_rdata carries the addressed word for a read and 0 for a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Core fetch request |
| fetch_addr | input | 14 | Fetch byte address |
| fetch_ready | output | 1 | Fetch accepted this cycle |
| fetch_valid | output | 1 | Fetch response valid |
| fetch_err | output | 1 | Fetch refused (memory disabled) |
| fetch_data | output | 64 | Fetched instruction word |
| dma_req | input | 1 | DMA request |
| dma_we | input | 1 | DMA write (1) or read (0) |
| dma_addr | input | 14 | DMA byte address |
| dma_be | input | 8 | DMA byte enables |
| dma_wdata | input | 64 | DMA write data |
| dma_ready | output | 1 | DMA accepted this cycle |
| dma_valid | output | 1 | DMA response valid |
| dma_err | output | 1 | DMA refused (memory disabled) |
| dma_rdata | output | 64 | DMA read data |
| dp_req | input | 1 | Data-path access into this space |
| dp_exc | output | 1 | Exception pulse for a data-path access |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 2 | New control value {cache_mode, enable} |
| priv_mode | input | 2 | 0 user, 1 supervisor, 2 emulation, 3 reserved |
| cfg_q | output | 2 | Current control value |

## Verification
A fetch and a DMA access can land in the same cycle, and the sub-bank each one targets decides whether both proceed or the fetch is held. The bench drives paired requests to distinct sub-banks, and to the same sub-bank over several cycles with the fetch held. A behavioural model makes the grant decision from the address fields alone and stores memory as a word-addressed map. The model's fetch_ready is compared right after the inputs change. Both responses are compared on every following cycle, which shows that the held fetch is neither lost nor duplicated.

// File: rtl/imem_pkg.sv
package imem_pkg;
  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_EMU   = 2'd2,
    PRIV_RSVD  = 2'd3
  } priv_e;

  localparam int CFG_W         = 2;
  localparam int CFG_EN_BIT    = 0;
  localparam int CFG_CACHE_BIT = 1;
  localparam logic [CFG_W-1:0] CFG_RESET = 2'b01;

  function automatic logic priv_may_write(input logic [1:0] p);
    return (p == PRIV_SUPER) || (p == PRIV_EMU);
  endfunction

  function automatic logic cfg_serviced(input logic [CFG_W-1:0] c);
    return c[CFG_EN_BIT] && !c[CFG_CACHE_BIT];
  endfunction
endpackage

// File: rtl/imem_bank.sv
module imem_bank #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 512
) (
  input  logic                       clk,
  input  logic                       en,
  input  logic                       we,
  input  logic [$clog2(DEPTH)-1:0]   idx,
  input  logic [DATA_W/8-1:0]        be,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata
);
  localparam int BE_W = DATA_W / 8;

  logic [DATA_W-1:0] store [DEPTH];

  function automatic logic [DATA_W-1:0] merge_bytes(
    input logic [DATA_W-1:0] old_w,
    input logic [DATA_W-1:0] new_w,
    input logic [BE_W-1:0]   mask
  );
    logic [DATA_W-1:0] r;
    r = old_w;
    for (int i = 0; i < BE_W; i++)
      if (mask[i]) r[8*i +: 8] = new_w[8*i +: 8];
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) store[idx] <= merge_bytes(store[idx], wdata, be);
      else    rdata      <= store[idx];
    end
  end
endmodule

// File: rtl/imem_arbiter.sv
module imem_arbiter #(
  parameter int NUM_BANKS = 4
) (
  input  logic                          mem_on,
  input  logic                          fetch_req,
  input  logic [$clog2(NUM_BANKS)-1:0]  fetch_bank,
  input  logic                          dma_req,
  input  logic [$clog2(NUM_BANKS)-1:0]  dma_bank,
  output logic                          fetch_grant,
  output logic                          collision,
  output logic [NUM_BANKS-1:0]          bank_en,
  output logic [NUM_BANKS-1:0]          bank_dma
);
  assign collision   = fetch_req && dma_req && (fetch_bank == dma_bank);
  assign fetch_grant = fetch_req && !collision;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
    logic dma_hit, fetch_hit;
    assign dma_hit    = dma_req && (dma_bank == b);
    assign fetch_hit  = fetch_grant && (fetch_bank == b);
    assign bank_dma[b] = dma_hit;
    assign bank_en[b]  = mem_on && (dma_hit || fetch_hit);
  end
endmodule

// File: rtl/imem_cfg_reg.sv
module imem_cfg_reg
  import imem_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  input  logic [1:0]       priv,
  output logic [CFG_W-1:0] q,
  output logic             mem_on
);
  logic write_ok;
  assign write_ok = we && priv_may_write(priv);

  always_ff @(posedge clk) begin
    if (!rst_n)        q <= CFG_RESET;
    else if (write_ok) q <= wdata;
  end

  assign mem_on = cfg_serviced(q);
endmodule

// File: rtl/imem_dual_sram.sv
module imem_dual_sram
  import imem_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int DATA_W    = 64,
  parameter int NUM_BANKS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fetch_req,
  input  logic [ADDR_W-1:0]   fetch_addr,
  output logic                fetch_ready,
  output logic                fetch_valid,
  output logic                fetch_err,
  output logic [DATA_W-1:0]   fetch_data,
  input  logic                dma_req,
  input  logic                dma_we,
  input  logic [ADDR_W-1:0]   dma_addr,
  input  logic [DATA_W/8-1:0] dma_be,
  input  logic [DATA_W-1:0]   dma_wdata,
  output logic                dma_ready,
  output logic                dma_valid,
  output logic                dma_err,
  output logic [DATA_W-1:0]   dma_rdata,
  input  logic                dp_req,
  output logic                dp_exc,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_wdata,
  input  logic [1:0]          priv_mode,
  output logic [1:0]          cfg_q
);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int IDX_W  = ADDR_W - BANK_W - BYTE_W;
  localparam int DEPTH  = 1 << IDX_W;

  function automatic logic [BANK_W-1:0] bank_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: BANK_W];
  endfunction

  function automatic logic [IDX_W-1:0] index_of(input logic [ADDR_W-1:0] a);
    return a[BYTE_W +: IDX_W];
  endfunction

  logic [BYTE_W-1:0] unused_low;
  assign unused_low = fetch_addr[BYTE_W-1:0] ^ dma_addr[BYTE_W-1:0];

  logic [BANK_W-1:0] f_bank, d_bank;
  logic [IDX_W-1:0]  f_idx, d_idx;
  assign f_bank = bank_of(fetch_addr);
  assign d_bank = bank_of(dma_addr);
  assign f_idx  = index_of(fetch_addr);
  assign d_idx  = index_of(dma_addr);

  logic mem_on;
  imem_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .priv(priv_mode), .q(cfg_q), .mem_on(mem_on)
  );

  logic                 fetch_grant, coll_w;
  logic [NUM_BANKS-1:0] bank_en, bank_dma;
  imem_arbiter #(.NUM_BANKS(NUM_BANKS)) u_arb (
    .mem_on(mem_on), .fetch_req(fetch_req), .fetch_bank(f_bank),
    .dma_req(dma_req), .dma_bank(d_bank), .fetch_grant(fetch_grant),
    .collision(coll_w), .bank_en(bank_en), .bank_dma(bank_dma)
  );

  logic [DATA_W-1:0] bank_rd [NUM_BANKS];
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    imem_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank (
      .clk   (clk),
      .en    (bank_en[b]),
      .we    (bank_dma[b] && dma_we),
      .idx   (bank_dma[b] ? d_idx : f_idx),
      .be    (dma_be),
      .wdata (dma_wdata),
      .rdata (bank_rd[b])
    );
  end

  logic              fv_q, ferr_q, dv_q, derr_q, drd_q, exc_q;
  logic [BANK_W-1:0] fbank_q, dbank_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fv_q <= 1'b0; ferr_q <= 1'b0; dv_q <= 1'b0; derr_q <= 1'b0;
      drd_q <= 1'b0; exc_q <= 1'b0; fbank_q <= '0; dbank_q <= '0;
    end else begin
      fv_q    <= fetch_grant;
      ferr_q  <= fetch_grant && !mem_on;
      fbank_q <= f_bank;
      dv_q    <= dma_req;
      derr_q  <= dma_req && !mem_on;
      drd_q   <= dma_req && !dma_we;
      dbank_q <= d_bank;
      exc_q   <= dp_req;
    end
  end

  assign fetch_ready = fetch_grant;
  assign fetch_valid = fv_q;
  assign fetch_err   = ferr_q;
  assign fetch_data  = (fv_q && !ferr_q) ? bank_rd[fbank_q] : '0;
  assign dma_ready   = dma_req;
  assign dma_valid   = dv_q;
  assign dma_err     = derr_q;
  assign dma_rdata   = (dv_q && !derr_q && drd_q) ? bank_rd[dbank_q] : '0;
  assign dp_exc      = exc_q;
endmodule

// File: rtl/imem_dual_sram_chk.sv
module imem_dual_sram_chk #(
  parameter int ADDR_W    = 14,
  parameter int DATA_W    = 64,
  parameter int NUM_BANKS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_req,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              fetch_ready,
  input logic              fetch_valid,
  input logic              fetch_err,
  input logic [DATA_W-1:0] fetch_data,
  input logic              dma_req,
  input logic [ADDR_W-1:0] dma_addr,
  input logic              dma_ready,
  input logic              dma_valid,
  input logic              dp_req,
  input logic              dp_exc,
  input logic              cfg_we,
  input logic [1:0]        priv_mode,
  input logic [1:0]        cfg_q
);
  localparam int BANK_W = $clog2(NUM_BANKS);

  logic same_bank;
  assign same_bank = fetch_addr[ADDR_W-1 -: BANK_W] == dma_addr[ADDR_W-1 -: BANK_W];

  // R5
  collision_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && dma_req && same_bank) |-> (!fetch_ready && dma_ready));

  // R4
  dual_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && dma_req && !same_bank) |-> (fetch_ready && dma_ready));

  // R3
  fetch_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ready |=> fetch_valid);

  // R5
  no_resp_when_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_ready |=> !fetch_valid);

  // R6
  dp_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dp_req |=> dp_exc);

  // R7
  user_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (priv_mode == 2'd0 || priv_mode == 2'd3)) |=> $stable(cfg_q));

  // R8
  disabled_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_ready && cfg_q != 2'b01) |=> (fetch_err && fetch_data == '0));

  // R9
  dma_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |=> dma_valid);
endmodule

bind imem_dual_sram imem_dual_sram_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS)
) u_chk (.*);

// File: tb/imem_dual_sram_bench.sv
`timescale 1ns/100ps
module imem_dual_sram_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_req = 0;  logic [13:0] fetch_addr = 0;
  logic        fetch_ready, fetch_valid, fetch_err;
  logic [63:0] fetch_data;
  logic        dma_req = 0, dma_we = 0;
  logic [13:0] dma_addr = 0;
  logic [7:0]  dma_be = 0;
  logic [63:0] dma_wdata = 0;
  logic        dma_ready, dma_valid, dma_err;
  logic [63:0] dma_rdata;
  logic        dp_req = 0, dp_exc;
  logic        cfg_we = 0;
  logic [1:0]  cfg_wdata = 0, priv_mode = 0, cfg_q;

  always #2.5 clk = ~clk;

  imem_dual_sram u_imem_dual_sram (.*);

  int tests = 0, fails = 0, cycles = 0;
  string cur_tag = "R1", tag_q = "R1";

  // reference model state
  logic [63:0] mem_m [int];
  logic [1:0]  cfg_m = 2'b01;
  logic e_fv = 0, e_ferr = 0, e_fknown = 0, e_dv = 0, e_derr = 0, e_dknown = 0, e_exc = 0;
  logic [63:0] e_fdata = 0, e_drdata = 0;

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag_q, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      cfg_m = 2'b01; e_fv = 0; e_ferr = 0; e_dv = 0; e_derr = 0; e_exc = 0;
      e_fknown = 0; e_dknown = 0;
    end else begin
      bit on, grant;
      int fw, dw;
      logic [63:0] w;
      on    = (cfg_m == 2'b01);
      grant = fetch_req && !(dma_req && fetch_addr[13:12] == dma_addr[13:12]);
      fw    = int'(fetch_addr >> 3);
      dw    = int'(dma_addr >> 3);
      e_fv = grant; e_ferr = grant && !on;
      if (!on) begin e_fdata = 0; e_fknown = 1; end
      else begin e_fknown = mem_m.exists(fw); e_fdata = e_fknown ? mem_m[fw] : 0; end
      e_dv = dma_req; e_derr = dma_req && !on;
      if (!on || dma_we) begin e_drdata = 0; e_dknown = 1; end
      else begin e_dknown = mem_m.exists(dw); e_drdata = e_dknown ? mem_m[dw] : 0; end
      if (on && dma_req && dma_we) begin
        w = mem_m.exists(dw) ? mem_m[dw] : 64'h0;
        for (int i = 0; i < 8; i++) if (dma_be[i]) w[8*i +: 8] = dma_wdata[8*i +: 8];
        if (dma_be == 8'hFF || mem_m.exists(dw)) mem_m[dw] = w;
      end
      e_exc = dp_req;
      if (cfg_we && (priv_mode == 2'd1 || priv_mode == 2'd2)) cfg_m = cfg_wdata;
    end
    tag_q = cur_tag;
    if (cycles > 50000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    chk("fetch_valid", fetch_valid, e_fv);
    if (e_fv) chk("fetch_err", fetch_err, e_ferr);
    if (e_fv && e_fknown) chk("fetch_data", fetch_data, e_fdata);
    chk("dma_valid", dma_valid, e_dv);
    if (e_dv) chk("dma_err", dma_err, e_derr);
    if (e_dv && e_dknown) chk("dma_rdata", dma_rdata, e_drdata);
    chk("dp_exc", dp_exc, e_exc);
    chk("cfg_q", cfg_q, cfg_m);
  end

  task automatic tick();
    #1;
    chk("fetch_ready", fetch_ready,
        fetch_req && !(dma_req && fetch_addr[13:12] == dma_addr[13:12]));
    chk("dma_ready", dma_ready, dma_req);
    @(negedge clk);
  endtask

  task automatic idle();
    fetch_req = 0; dma_req = 0; dp_req = 0; cfg_we = 0;
  endtask

  task automatic dwrite(input logic [13:0] a, input logic [63:0] d, input logic [7:0] be);
    idle(); dma_req = 1; dma_we = 1; dma_addr = a; dma_wdata = d; dma_be = be; tick();
  endtask

  task automatic dread(input logic [13:0] a);
    idle(); dma_req = 1; dma_we = 0; dma_addr = a; tick();
  endtask

  task automatic fetch(input logic [13:0] a);
    idle(); fetch_req = 1; fetch_addr = a; tick();
  endtask

  task automatic cfgw(input logic [1:0] p, input logic [1:0] v);
    idle(); cfg_we = 1; priv_mode = p; cfg_wdata = v; tick();
  endtask

  initial begin
    cur_tag = "R1";
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst_n = 1; tick(); tick();

    cur_tag = "R2";
    for (int b = 0; b < 4; b++)
      for (int k = 0; k < 3; k++)
        dwrite(14'(b*4096 + k*8 + (k == 2 ? 4088 - 16 : 0)), {32'hA5A5_0000 + 32'(b), 32'(k) * 32'h1111_0101}, 8'hFF);
    dwrite(14'h0008, 64'hDEAD_BEEF_CAFE_F00D, 8'h0F);
    dwrite(14'h1000, 64'h1122_3344_5566_7788, 8'hA5);
    idle(); tick();

    cur_tag = "R3";
    fetch(14'h0008); fetch(14'h0000); fetch(14'h100D); fetch(14'h2FFF);
    fetch(14'h3008); fetch(14'h1000);
    idle(); tick();

    cur_tag = "R9";
    dread(14'h0008); dread(14'h2000); dread(14'h3FFB);
    idle(); tick();

    cur_tag = "R4";
    idle(); fetch_req = 1; fetch_addr = 14'h0000; dma_req = 1; dma_we = 0; dma_addr = 14'h2008; tick();
    idle(); fetch_req = 1; fetch_addr = 14'h1008; dma_req = 1; dma_we = 1; dma_addr = 14'h3010;
    dma_wdata = 64'h0F0F_0F0F_1234_5678; dma_be = 8'hFF; tick();
    fetch(14'h3010);
    idle(); tick();

    cur_tag = "R5";
    idle(); fetch_req = 1; fetch_addr = 14'h1008; dma_req = 1; dma_we = 1; dma_addr = 14'h1008;
    dma_wdata = 64'h5555_AAAA_5555_AAAA; dma_be = 8'hFF; tick();
    dma_we = 0; dma_addr = 14'h1FF0; tick();
    dma_req = 0; tick();
    idle(); fetch_req = 1; fetch_addr = 14'h0000; dma_req = 1; dma_we = 0; dma_addr = 14'h0008; tick();
    dma_addr = 14'h3000; tick();
    idle(); tick();

    cur_tag = "R6";
    idle(); dp_req = 1; tick();
    idle(); tick();
    idle(); dp_req = 1; fetch_req = 1; fetch_addr = 14'h2000; tick();
    dp_req = 1; tick();
    idle(); tick();

    cur_tag = "R7";
    cfgw(2'd0, 2'b00); cfgw(2'd3, 2'b10); idle(); fetch(14'h0000);
    cfgw(2'd1, 2'b00);

    cur_tag = "R8";
    fetch(14'h0008);
    dwrite(14'h0008, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);
    dread(14'h2000);
    cfgw(2'd2, 2'b11); fetch(14'h1000); dwrite(14'h1000, 64'h0, 8'hFF);
    cfgw(2'd2, 2'b10); fetch(14'h1000);
    cfgw(2'd1, 2'b01);
    fetch(14'h0008); dread(14'h1000);
    idle(); tick(); tick();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule